// File: doc/BRIEF.md
# Pixel-Array Color Multiplexer Sequencer

This block decides, line by line, which of three video color channels each output column of a display column driver samples. The choice depends on the panel's color filter layout. A vertical stripe panel uses the same pattern on every line. The two delta layouts alternate between two patterns. The mosaic layout steps through three patterns. Each line boundary is marked by a falling edge of an inhibit strobe. The inhibit input is sampled on the rising clock edge, and a fall is seen when the strobe is sampled high at one edge and low at the next.

A small state machine has three states: `ST_DARK` (multiplexer off), `ST_PRIME` (one undefined line) and `ST_LIVE` (selection active). Its transitions are:
- `T_RESET`: any state to `ST_DARK` while reset is high.
- `T_WAKE_STRIPE`: `ST_DARK` to `ST_LIVE` on a fall, stripe layout.
- `T_WAKE_PRIME`: `ST_DARK` to `ST_PRIME` on a fall, other layouts.
- `T_PRIME_LIVE`: `ST_PRIME` to `ST_LIVE` on a fall.
- `T_LIVE_STEP`: `ST_LIVE` to itself on a fall, advancing the line phase modulo the layout's cycle length.

The layout pins are captured only while reset is high. The shift-direction pin mirrors the column order and is applied combinationally. Each column's 2-bit code is decoded from the column's position modulo three and the current line phase.

Top module: `pix_colmux_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, every column code is 00 (disabled).
- R2: When reset is high in the same cycle as an inhibit fall, reset wins. That fall is not counted, so the next fall after reset is the first one.
- R3: The layout pins {layout_pins[1], layout_pins[0]} encode the layout: 00 stripe, 01 single-side delta, 10 mosaic, 11 double-side delta. In stripe layout, the first fall after reset enables the columns with line form 0. In the other layouts, the first fall leaves every column at 00, and the second fall enables form 0. Columns are never partly enabled.
- R4: Column k (1-based) occupies col_code bits [2k-1:2k-2], and the codes are 01 = C1, 10 = C2, 11 = C3. In stripe layout with right shift, column k carries channel ((k-1) mod 3)+1 on every line.
- R5: In single-side delta layout with right shift, the forms alternate per line. Column 1 takes C1 in form 0 and C2 in form 1. The following columns step upward C1→C2→C3→C1.
- R6: In mosaic layout with right shift, column 1 takes C1, C3, C2 over three successive lines and then repeats. The following columns step upward.
- R7: In double-side delta layout with right shift, column 1 takes C2 in form 0 and C1 in form 1, alternating per line. The following columns step upward.
- R8: With left shift, counting starts at the last column N and steps downward C3→C2→C1→C3. In stripe layout, column N is C3 on every line. In single-side delta layout, column N alternates C3, C1.
- R9: With left shift in mosaic layout, column N takes C3, C2, C1 over three lines. In double-side delta layout with left shift, column N alternates C3, C1. Both count from column N downward as in R8.
- R10: Layout pin changes made while reset is low have no effect until the next reset.
- R11: With the direction held, codes change only on an inhibit fall. A rising edge or a steady level leaves every code unchanged.
- R12: A change of the direction pin re-maps the current line's form at once, without advancing the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the layout pins |
| inh | input | 1 | Inhibit line strobe; a falling edge marks a new line |
| layout_pins | input | 2 | Color filter layout select |
| shift_right | input | 1 | 1 = right shift, 0 = left shift |
| col_code | output | 2*NCOL | Per-column channel code, column 1 in the low bits |

## Verification
Reset and an inhibit fall can land in the same clock cycle. The bench provokes this by dropping the strobe at the very edge where reset is asserted, using a delta layout. It judges the outcome by checking that the first fall after release still yields all-disabled columns and that only the second fall brings form 0. A direction change can also coincide with a held line. The bench flips the direction mid-line and compares the whole column vector against the mirrored form of the same line.

// File: rtl/pix_colmux_pkg.sv
package pix_colmux_pkg;

    localparam int CODE_W = 2;
    localparam logic [CODE_W-1:0] CODE_OFF = 2'b00;

    typedef enum logic [1:0] {
        LAY_STRIPE    = 2'b00,
        LAY_DELTA_ONE = 2'b01,
        LAY_MOSAIC    = 2'b10,
        LAY_DELTA_TWO = 2'b11
    } layout_e;

    typedef enum logic [1:0] {
        ST_DARK  = 2'b00,
        ST_PRIME = 2'b01,
        ST_LIVE  = 2'b10
    } seq_state_e;

    // last line phase before wrapping: cycle length minus one
    function automatic logic [1:0] phase_last(input layout_e lay);
        logic [1:0] r;
        case (lay)
            LAY_STRIPE:    r = 2'd0;
            LAY_MOSAIC:    r = 2'd2;
            default:       r = 2'd1;
        endcase
        return r;
    endfunction

    // channel index (0..2) of the leading column: column 1 for right
    // shift, column N for left shift
    function automatic logic [1:0] lead_index(input layout_e lay,
                                              input logic right,
                                              input logic [1:0] phase);
        logic [1:0] r;
        case (lay)
            LAY_STRIPE:
                r = right ? 2'd0 : 2'd2;
            LAY_DELTA_ONE:
                if (right) r = phase[0] ? 2'd1 : 2'd0;
                else       r = phase[0] ? 2'd0 : 2'd2;
            LAY_MOSAIC:
                if (right) begin
                    case (phase)
                        2'd0:    r = 2'd0;
                        2'd1:    r = 2'd2;
                        default: r = 2'd1;
                    endcase
                end else begin
                    case (phase)
                        2'd0:    r = 2'd2;
                        2'd1:    r = 2'd1;
                        default: r = 2'd0;
                    endcase
                end
            default:
                if (right) r = phase[0] ? 2'd0 : 2'd1;
                else       r = phase[0] ? 2'd0 : 2'd2;
        endcase
        return r;
    endfunction

    // sum modulo three of two operands in 0..2
    function automatic logic [1:0] mod3_add(input logic [1:0] a,
                                            input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

endpackage

// File: rtl/pix_colmux_fall_det.sv
module pix_colmux_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    // cleared during reset so a drop coinciding with reset is never seen
    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    always_comb fall = strobe_q & ~strobe & ~rst;
endmodule

// File: rtl/pix_colmux_line_fsm.sv
module pix_colmux_line_fsm
    import pix_colmux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fall,
    input  logic [1:0] layout_pins,
    output seq_state_e state_q,
    output layout_e    layout_q,
    output logic [1:0] phase_q,
    output logic       live
);
    seq_state_e state_d;
    logic [1:0] phase_step;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DARK;                     // T_RESET
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DARK:
                if (fall) state_d = (layout_q == LAY_STRIPE) ? ST_LIVE   // T_WAKE_STRIPE
                                                             : ST_PRIME; // T_WAKE_PRIME
            ST_PRIME:
                if (fall) state_d = ST_LIVE;             // T_PRIME_LIVE
            ST_LIVE:
                state_d = ST_LIVE;                       // T_LIVE_STEP
            default:
                state_d = ST_DARK;
        endcase
    end

    always_comb begin
        if (phase_q == phase_last(layout_q)) phase_step = 2'd0;
        else                                 phase_step = phase_q + 2'd1;
    end

    // layout capture and line phase
    always_ff @(posedge clk) begin
        if (rst) begin
            layout_q <= layout_e'(layout_pins);
            phase_q  <= 2'd0;
        end else if (fall && state_q == ST_LIVE) begin
            phase_q  <= phase_step;
        end
    end

    // outputs
    always_comb live = (state_q == ST_LIVE);
endmodule

// File: rtl/pix_colmux_col_map.sv
module pix_colmux_col_map
    import pix_colmux_pkg::*;
#(
    parameter int NCOL = 240
) (
    input  logic                   live,
    input  layout_e                layout_q,
    input  logic                   shift_right,
    input  logic [1:0]             phase_q,
    output logic [CODE_W*NCOL-1:0] col_code
);
    logic [1:0] lead;

    always_comb lead = lead_index(layout_q, shift_right, phase_q);

    for (genvar g = 0; g < NCOL; g++) begin : g_col
        localparam logic [1:0] RPOS = 2'(g % 3);
        localparam logic [1:0] LNEG = 2'((3 - ((NCOL - 1 - g) % 3)) % 3);
        logic [1:0] idx;

        always_comb begin
            idx = shift_right ? mod3_add(lead, RPOS) : mod3_add(lead, LNEG);
            col_code[CODE_W*g +: CODE_W] = live ? (idx + 2'd1) : CODE_OFF;
        end
    end
endmodule

// File: rtl/pix_colmux_seq.sv
module pix_colmux_seq
    import pix_colmux_pkg::*;
#(
    parameter int NCOL = 240
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   inh,
    input  logic [1:0]             layout_pins,
    input  logic                   shift_right,
    output logic [CODE_W*NCOL-1:0] col_code
);
    logic       fall;
    seq_state_e state_q;
    layout_e    layout_q;
    logic [1:0] phase_q;
    logic       live;

    pix_colmux_fall_det edge_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (inh),
        .fall   (fall)
    );

    pix_colmux_line_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .fall        (fall),
        .layout_pins (layout_pins),
        .state_q     (state_q),
        .layout_q    (layout_q),
        .phase_q     (phase_q),
        .live        (live)
    );

    pix_colmux_col_map #(.NCOL(NCOL)) map_i (
        .live        (live),
        .layout_q    (layout_q),
        .shift_right (shift_right),
        .phase_q     (phase_q),
        .col_code    (col_code)
    );
endmodule

// File: rtl/pix_colmux_seq_chk.sv
module pix_colmux_seq_chk
    import pix_colmux_pkg::*;
#(
    parameter int NCOL = 240
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   inh,
    input logic                   shift_right,
    input logic [CODE_W*NCOL-1:0] col_code,
    input seq_state_e             state_q,
    input layout_e                layout_q
);
    logic inh_d;
    logic fall_c;
    int   dark_cnt;

    always_ff @(posedge clk) begin
        if (rst) inh_d <= 1'b0;
        else     inh_d <= inh;
    end

    always_comb fall_c = inh_d & ~inh;

    always_comb begin
        dark_cnt = 0;
        for (int k = 0; k < NCOL; k++)
            if (col_code[CODE_W*k +: CODE_W] == CODE_OFF) dark_cnt++;
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> (col_code == '0)); // R1

    AST_NO_PARTIAL_DARK: assert property (@(posedge clk) disable iff (rst)
        (dark_cnt != 0) |-> (dark_cnt == NCOL)); // R3

    AST_PRIME_DARK: assert property (@(posedge clk) disable iff (rst)
        (fall_c && state_q == ST_DARK && layout_q != LAY_STRIPE) |=> (col_code == '0)); // R3

    AST_STRIPE_LEAD: assert property (@(posedge clk) disable iff (rst)
        (layout_q == LAY_STRIPE && shift_right && col_code[1:0] != CODE_OFF)
            |-> (col_code[1:0] == 2'b01)); // R4

    AST_LAYOUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(layout_q)); // R10

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !fall_c |=> ($stable(col_code) || !$stable(shift_right))); // R11
endmodule

bind pix_colmux_seq pix_colmux_seq_chk #(.NCOL(NCOL)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .inh         (inh),
    .shift_right (shift_right),
    .col_code    (col_code),
    .state_q     (state_q),
    .layout_q    (layout_q)
);

// File: tb/pix_colmux_seq_tb.sv
`timescale 1ns/1ps
module pix_colmux_seq_tb_top;
    localparam int NC = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            inh = 1'b0;
    logic [1:0]      layout_pins = 2'b00;
    logic            shift_right = 1'b1;
    logic [2*NC-1:0] col_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pix_colmux_seq #(.NCOL(NC)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .inh         (inh),
        .layout_pins (layout_pins),
        .shift_right (shift_right),
        .col_code    (col_code)
    );

    // channel index (0..2) of column 1 (right) or column NC (left)
    function automatic int lead_of(int lay, bit right, int line);
        case (lay)
            0: return right ? 0 : 2;
            1: return right ? (line % 2) : ((line % 2) ? 0 : 2);
            2: return right ? ((3 - line % 3) % 3) : (2 - line % 3);
            default: return right ? ((line % 2) ? 0 : 1) : ((line % 2) ? 0 : 2);
        endcase
    endfunction

    function automatic logic [2*NC-1:0] form_vec(int lay, bit right, int line);
        logic [2*NC-1:0] v;
        int lead;
        lead = lead_of(lay, right, line);
        for (int k = 1; k <= NC; k++) begin
            int idx;
            if (right) idx = (lead + (k - 1)) % 3;
            else       idx = (lead + 3 - ((NC - k) % 3)) % 3;
            v[2*(k-1) +: 2] = 2'(idx + 1);
        end
        return v;
    endfunction

    function automatic string tag_of(int lay, bit right);
        if (right) begin
            case (lay)
                0: return "R4";
                1: return "R5";
                2: return "R6";
                default: return "R7";
            endcase
        end
        return (lay < 2) ? "R8" : "R9";
    endfunction

    task automatic check_vec(input logic [2*NC-1:0] exp, input string tag);
        checks++;
        if (col_code !== exp) begin
            fails++;
            $display("FAIL %s: col_code=%h expected %h", tag, col_code, exp);
        end
    endtask

    task automatic do_reset(input int lay);
        @(negedge clk);
        rst = 1'b1;
        inh = 1'b0;
        layout_pins = 2'(lay);
        @(negedge clk);
        check_vec('0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_vec('0, "R1 after release");
    endtask

    // one strobe pulse; returns at the sampling point after the fall edge
    task automatic pulse();
        @(negedge clk);
        inh = 1'b1;
        @(negedge clk);
        inh = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        // layout and direction sweep
        for (int lay = 0; lay < 4; lay++) begin
            for (int d = 0; d < 2; d++) begin
                shift_right = d[0];
                do_reset(lay);
                pulse();
                if (lay != 0) begin
                    check_vec('0, "R3 prime line dark");
                    pulse();
                end
                for (int line = 0; line < 7; line++) begin
                    check_vec(form_vec(lay, d[0], line), tag_of(lay, d[0]));
                    if (line < 6) pulse();
                end
                // reset from live state
                do_reset(lay);
            end
        end

        // R2: reset coincident with a strobe fall, single-side delta
        shift_right = 1'b1;
        do_reset(1);
        @(negedge clk);
        inh = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        inh = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_vec('0, "R2 reset wins");
        pulse();
        check_vec('0, "R2 first fall after reset primes");
        pulse();
        check_vec(form_vec(1, 1'b1, 0), "R2 second fall enables form 0");

        // R10: layout change without reset ignored
        do_reset(2);
        layout_pins = 2'b00;
        pulse();
        check_vec('0, "R10 still mosaic prime");
        pulse();
        pulse();
        check_vec(form_vec(2, 1'b1, 1), "R10 mosaic line 1");
        layout_pins = 2'b11;
        pulse();
        check_vec(form_vec(2, 1'b1, 2), "R10 mosaic line 2");

        // R12: direction flip mid-line keeps the line
        shift_right = 1'b0;
        @(negedge clk);
        check_vec(form_vec(2, 1'b0, 2), "R12 left form same line");
        shift_right = 1'b1;
        @(negedge clk);
        check_vec(form_vec(2, 1'b1, 2), "R12 back to right");

        // R11: rising edge and steady high do not advance
        @(negedge clk);
        inh = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_vec(form_vec(2, 1'b1, 2), "R11 held high");
        end
        inh = 1'b0;
        @(negedge clk);
        check_vec(form_vec(2, 1'b1, 0), "R11 fall wraps to line 0");
        repeat (3) @(negedge clk);
        check_vec(form_vec(2, 1'b1, 0), "R11 steady low");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule